// File: doc/BRIEF.md
# Cipher key form tracker

This block sits next to a block cipher engine whose primary key register can hold either the forward (encryption) key schedule or the inverse (decryption) key schedule. A hidden flag tracks which form the stored key is in. Each data block comes with a request that carries a 3-bit chaining-mode code and a direction bit. The block decodes whether that request needs the inverse cipher. If the stored form does not match, it first commands a key-schedule engine to convert the key in the required direction. It releases the block only after the conversion has finished.

Software never rekeys on a change of mode, direction or key size. When a forward-cipher operation follows an inverse one, the key is converted back to its forward form automatically. Any write to any word of either key register means the register again holds a freshly written forward key, so the write clears the flag. The conversion arithmetic is outside this block. It sees only a start pulse with a direction and a done pulse in return. A conversion always occupies a fixed number of cycles (32 by default), even if the engine reports done earlier.

Top module: `key_form_tracker`

## Requirements
- R1: After reset `busy_o`, `blk_go_o` and `conv_start_o` are low and the key is taken to be in forward form, so a first forward request is released at once.
- R2: The inverse cipher is needed exactly when `decrypt_i` is 1 and `mode_i` is 0 (ECB), 1 (CBC) or 4 (XTS). Codes 2, 3, 5, 6 and 7 and every request with `decrypt_i` 0 use the forward cipher.
- R3: When idle and the stored form matches the need of a pending `blk_req_i`, `blk_go_o` is high in that same cycle and no conversion starts.
- R4: When idle and the form does not match, `conv_start_o` pulses for exactly that cycle. `conv_dir_o` is 1 for a conversion to inverse form and 0 for one back to forward form. `busy_o` rises on the next cycle.
- R5: `blk_go_o` stays low while `busy_o` is high. A request that caused a conversion is released in the first idle cycle after the conversion, provided the key was not rewritten meanwhile.
- R6: A conversion ends only when `CONV_CYCLES` busy cycles have elapsed and `conv_done_i` has been seen. An early done is remembered. A late done stretches the busy time until the cycle in which it arrives.
- R7: After a conversion the stored form equals the converted direction. Later requests with the same need are released at once, whatever their mode code.
- R8: A forward request while the key is in inverse form triggers a conversion with `conv_dir_o` = 0 before the block is released.
- R9: `key_wr_i` clears the stored form to forward. A write in the same cycle as a request already counts for that request.
- R10: A key write during a conversion discards its result. The form becomes forward, and a still-pending inverse request starts a new conversion.
- R11: `conv_dir_o` stays constant during a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Chaining-mode code of the pending block |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt |
| blk_req_i | input | 1 | Block pending; held until `blk_go_o` |
| key_wr_i | input | 1 | A word of either key register is written this cycle |
| conv_done_i | input | 1 | Key-schedule engine finished the conversion |
| blk_go_o | output | 1 | Block may be processed this cycle |
| busy_o | output | 1 | Conversion in progress |
| conv_start_o | output | 1 | One-cycle command to start a conversion |
| conv_dir_o | output | 1 | Conversion target: 1 inverse form, 0 forward form |

## Verification
The bench builds the block with the default `CONV_CYCLES` of 32 and the full 3-bit mode code. It sweeps all 8 codes in both directions, starting once from forward form and once from inverse form, so every entry of the decode table and both conversion directions are exercised. Each request uses a different engine done delay, spread from 1 to 45 cycles. The sweep therefore covers an early done that must be held, a done exactly at the 32-cycle mark, and late dones that stretch busy. Key writes are placed in the request cycle and in the middle of a conversion.

// File: rtl/key_form_pkg.sv
package key_form_pkg;
  localparam int unsigned MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_ECB = 3'd0;
  localparam logic [MODE_W-1:0] MODE_CBC = 3'd1;
  localparam logic [MODE_W-1:0] MODE_XTS = 3'd4;

  typedef enum logic {ST_IDLE = 1'b0, ST_CONV = 1'b1} kf_state_e;

  // Only ECB, CBC and XTS decryption run the inverse cipher.
  function automatic logic needs_inverse(input logic [MODE_W-1:0] mode, input logic decrypt);
    logic inv_mode;
    case (mode)
      MODE_ECB, MODE_CBC, MODE_XTS: inv_mode = 1'b1;
      default:                      inv_mode = 1'b0;
    endcase
    return decrypt & inv_mode;
  endfunction
endpackage

// File: rtl/kf_decode.sv
module kf_decode
  import key_form_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              decrypt_i,
  output logic              need_inv_o
);
  assign need_inv_o = needs_inverse(mode_i, decrypt_i);
endmodule

// File: rtl/kf_timer.sv
module kf_timer #(
  parameter int unsigned CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic elapsed_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign elapsed_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/kf_flag.sv
module kf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_en_i,
  input  logic set_val_i,
  output logic dec_o,
  output logic eff_dec_o
);
  logic dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dec_q <= 1'b0;
    else if (clr_i)    dec_q <= 1'b0;
    else if (set_en_i) dec_q <= set_val_i;
  end

  assign dec_o     = dec_q;
  assign eff_dec_o = dec_q & ~clr_i;

  // R9: key write leaves forward form
  a_r9_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !dec_o);
endmodule

// File: rtl/key_form_tracker.sv
module key_form_tracker
  import key_form_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              decrypt_i,
  input  logic              blk_req_i,
  input  logic              key_wr_i,
  input  logic              conv_done_i,
  output logic              blk_go_o,
  output logic              busy_o,
  output logic              conv_start_o,
  output logic              conv_dir_o
);
  kf_state_e state_q;
  logic need_inv, eff_dec, stored_dec, elapsed, fin, idle, match;
  logic target_q, done_seen_q, wr_seen_q;

  kf_decode u_dec (.mode_i(mode_i), .decrypt_i(decrypt_i), .need_inv_o(need_inv));

  assign idle  = (state_q == ST_IDLE);
  assign match = (need_inv == eff_dec);

  assign blk_go_o     = idle && blk_req_i && match;
  assign conv_start_o = idle && blk_req_i && !match;
  assign busy_o       = !idle;
  assign conv_dir_o   = idle ? need_inv : target_q;

  kf_timer #(.CYCLES(CONV_CYCLES)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(conv_start_o),
    .run_i(!idle), .elapsed_o(elapsed)
  );

  assign fin = !idle && elapsed && (done_seen_q || conv_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      target_q    <= 1'b0;
      done_seen_q <= 1'b0;
      wr_seen_q   <= 1'b0;
    end else if (conv_start_o) begin
      state_q     <= ST_CONV;
      target_q    <= need_inv;
      done_seen_q <= 1'b0;
      wr_seen_q   <= 1'b0;
    end else if (!idle) begin
      if (conv_done_i) done_seen_q <= 1'b1;
      if (key_wr_i)    wr_seen_q   <= 1'b1;
      if (fin)         state_q     <= ST_IDLE;
    end
  end

  // Result of a conversion overtaken by a key write is void.
  kf_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(key_wr_i),
    .set_en_i(fin), .set_val_i(target_q & ~wr_seen_q),
    .dec_o(stored_dec), .eff_dec_o(eff_dec)
  );

  // R4: start is a single pulse followed by busy
  a_r4_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> busy_o && !conv_start_o);
  // R5: no release during a conversion
  a_r5_no_go_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !blk_go_o);
  // R6: busy ends only after the timer has run out
  a_r6_min_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(elapsed));
  // R11: direction constant during conversion
  a_r11_dir_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(conv_dir_o));
  // R7: completed conversion without key write leaves target form
  a_r7_form_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && !wr_seen_q && !key_wr_i |=> stored_dec == $past(target_q));
endmodule

// File: tb/sim_key_form_tracker.sv
`timescale 1ns/1ps
module sim_key_form_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic dec = 1'b0, req = 1'b0, kw = 1'b0, done = 1'b0;
  logic go, busy, cstart, cdir;
  int n_chk = 0, n_bad = 0;
  bit m_dec = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  key_form_tracker #(.CONV_CYCLES(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .decrypt_i(dec),
    .blk_req_i(req), .key_wr_i(kw), .conv_done_i(done),
    .blk_go_o(go), .busy_o(busy), .conv_start_o(cstart), .conv_dir_o(cdir)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit need_of(input int m, input int d);
    return (d == 1) && (m == 0 || m == 1 || m == 4); // R2 decode
  endfunction

  // Runs one conversion tail: done at cycle 'delay', checks busy/go per R5, R6.
  task automatic run_conv(input int delay, input bit kw_mid, input bit need, input string tag);
    int goal;
    goal = ((delay > 32) ? delay : 32) + 1;
    for (int n = 1; n <= goal; n++) begin
      @(negedge clk);
      kw = kw_mid && (n == 5);
      done = (n == delay);
      #1;
      if (n < goal) begin
        if (n == 1 || n == goal - 1) begin
          check({tag, " R5 busy"}, busy, 1);
          check({tag, " R5 go held"}, go, 0);
        end
      end else if (kw_mid) begin
        check({tag, " R10 restart"}, cstart, 1);
        check({tag, " R10 dir"}, cdir, need);
        check({tag, " R10 no go"}, go, 0);
      end else begin
        check({tag, " R6 go"}, go, 1);
        check({tag, " R6 idle"}, busy, 0);
      end
    end
    done = 1'b0;
  endtask

  task automatic do_block(input int m, input int d, input int delay,
                          input bit kw_now, input bit kw_mid, input string tag);
    bit need, eff, conv;
    @(negedge clk);
    mode = 3'(m); dec = d[0]; req = 1'b1; kw = kw_now; done = 1'b0;
    need = need_of(m, d);
    eff  = m_dec && !kw_now;
    conv = (need != eff);
    #1;
    check({tag, " R3 go"}, go, !conv);
    check({tag, " R4 start"}, cstart, conv);
    if (conv) begin
      check({tag, need ? " R4 dir" : " R8 dir back"}, cdir, need);
      run_conv(delay, kw_mid, need, tag);
      if (kw_mid) run_conv(1, 1'b0, need, {tag, " R10 second"});
      m_dec = need;
    end else begin
      m_dec = eff;
    end
    @(negedge clk);
    req = 1'b0; kw = 1'b0; done = 1'b0;
  endtask

  task automatic key_write();
    @(negedge clk); kw = 1'b1;
    @(negedge clk); kw = 1'b0;
    m_dec = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 busy", busy, 0);
    check("R1 go", go, 0);
    check("R1 start", cstart, 0);
    do_block(2, 0, 1, 0, 0, "R1 first fwd");

    // R2 R7 R8 sweep: every mode and direction, from each starting form
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 8; m++)
        for (int d = 0; d < 2; d++) begin
          if (s == 0) key_write();
          else do_block(0, 1, 3, 0, 0, "R7 prep");
          do_block(m, d, (m * 5 + d * 7 + s * 11) % 45 + 1, 0, 0,
                   $sformatf("R2 m%0d d%0d s%0d", m, d, s));
        end

    // R7: inverse form kept across inverse mode changes
    do_block(0, 1, 32, 0, 0, "R7 ecb dec");
    do_block(4, 1, 1, 0, 0, "R7 xts dec no conv");
    do_block(1, 1, 1, 0, 0, "R7 cbc dec no conv");
    // R8: forward after inverse converts back
    do_block(3, 0, 40, 0, 0, "R8 cfb enc");
    // R9: write in request cycle
    do_block(0, 1, 2, 0, 0, "R9 prep");
    do_block(1, 1, 2, 1, 0, "R9 same-cycle inv");
    do_block(0, 1, 2, 0, 0, "R9 prep2");
    do_block(2, 0, 2, 1, 0, "R9 same-cycle fwd");
    // R9: idle write then inverse request reconverts
    do_block(0, 1, 2, 0, 0, "R9 prep3");
    key_write();
    do_block(0, 1, 33, 0, 0, "R9 after write");
    // R10: write during conversion
    key_write();
    do_block(4, 1, 10, 0, 1, "R10 mid write");
    do_block(4, 1, 1, 0, 0, "R10 form kept");
    // R11 with late done
    key_write();
    do_block(1, 1, 45, 0, 0, "R11 late done");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule